// File: doc/BRIEF.md
# 64-bit Periodic Interval Timer

A memory-mapped interval timer with a 64-bit count, driven through a simple 32-bit register bus: an address, a write strobe with write data, and a read strobe with combinational read data. Software programs a 64-bit period through two 32-bit words. It also chooses continuous or one-shot operation and a 4-bit prescale value P, and then starts the timer. The count advances once every P+1 clocks. When it reaches the period it raises a sticky match flag. In continuous mode it then restarts from zero. In one-shot mode it stops.

Software reads the live count as two words, low word first. Reading the low word captures the high word into a shadow register, so the 64-bit pair always belongs to one instant. A self-clearing software reset returns the counting state to idle and keeps the programmed configuration. Programming both period words to all ones turns the block into a free-running 64-bit counter.

Top module: `pit_timer64`

## Requirements
- R1: After the synchronous reset, every register reads 0, the timer is stopped, the count is 0 and `match_flag` is low.
- R2: Writing address 0x00 with bit 0 set and bit 8 clear while the timer is stopped starts it: the count restarts from 0 and the prescaler restarts. Bit 0 of address 0x00 reads 1 while the timer runs. A write of 0 to bit 0, and a start while already running, have no effect on the count or on the running state.
- R3: Writing address 0x00 with bit 8 set performs a software reset that takes precedence over bit 0. It clears the count, the prescaler, the running state and `match_flag`, and it keeps the mode and period registers. Bit 8 always reads 0.
- R4: Address 0x04 holds the continuous-mode select in bit 0 (1 = continuous) and the prescale value P in bits 11:8. Both read back at the same positions, and all other bits read 0.
- R5: While running, the count advances by one on every (P+1)-th clock edge after the start, and changes in no other way except a wrap to 0.
- R6: On an advance at which the count equals the active period, `match_flag` is set. It stays set until a software reset or an accepted start.
- R7: In continuous mode, the advance that matches the period loads 0 into the count.
- R8: In one-shot mode, the advance that matches the period stops the timer, and the count holds at the period value.
- R9: Addresses 0x08 and 0x0C hold the low and high period words. A write is staged and read back at once, but it becomes the active period only at the next accepted start or the next continuous-mode wrap.
- R10: Address 0x20 returns count bits 31:0, and a read of it captures count bits 63:32 into a shadow register. Address 0x24 returns that shadow value.
- R11: Reads of unmapped addresses return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe (captures the shadow word on a low-count read) |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| match_flag | output | 1 | Sticky period-match flag |

## Verification
The assertions check on every cycle the properties that hold at any moment. The count only steps by one or wraps to zero, and it stays frozen while the timer is stopped. The match flag stays set until a start or reset write. A software reset leaves the counting state idle on the next cycle. A low-count read captures exactly the high word of that cycle. The bench scenarios show the cycle counts: when the count reaches its value under each prescale setting, when a wrap or a one-shot stop occurs, and that a period written while running takes effect only after the next wrap. They also show that the configuration survives a software reset and that ignored writes change nothing at the ports.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 64;
    localparam int PRE_W  = 4;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] A_CTRL   = 8'h00;
    localparam logic [ADDR_W-1:0] A_MODE   = 8'h04;
    localparam logic [ADDR_W-1:0] A_PER_LO = 8'h08;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 8'h20;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 8'h24;

    localparam int GO_BIT   = 0;
    localparam int SRST_BIT = 8;
    localparam int CONT_BIT = 0;
    localparam int PRE_LSB  = 8;

    typedef struct packed {
        logic [PRE_W-1:0] presc;
        logic             cont;
    } mode_t;

    typedef struct packed {
        logic start;
        logic srst;
    } ctrl_req_t;

    function automatic logic [DATA_W-1:0] pack_mode(mode_t m);
        logic [DATA_W-1:0] r;
        r = '0;
        r[PRE_LSB +: PRE_W] = m.presc;
        r[CONT_BIT]         = m.cont;
        return r;
    endfunction

    function automatic mode_t unpack_mode(logic [DATA_W-1:0] w);
        mode_t m;
        m.presc = w[PRE_LSB +: PRE_W];
        m.cont  = w[CONT_BIT];
        return m;
    endfunction
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
    parameter int PW = pit_pkg::PRE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          run,
    input  logic [PW-1:0] limit,
    output logic          tick
);
    logic [PW-1:0] pc_q;
    logic          at_limit;

    assign at_limit = (pc_q >= limit);
    assign tick     = run && at_limit;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pc_q <= '0;
        end else if (run) begin
            if (at_limit) pc_q <= '0;
            else          pc_q <= pc_q + 1'b1;
        end
    end
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
    parameter int CW = pit_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          srst,
    input  logic          start,
    input  logic          tick,
    input  logic          cont,
    input  logic [CW-1:0] period_stage,
    output logic [CW-1:0] count,
    output logic          running,
    output logic          hit
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] per_act_q;
    logic          run_q;
    logic          at_period;

    assign at_period = (cnt_q == per_act_q);
    assign hit       = run_q && tick && at_period;
    assign count     = cnt_q;
    assign running   = run_q;

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            cnt_q     <= '0;
            per_act_q <= '0;
            run_q     <= 1'b0;
        end else if (start && !run_q) begin
            cnt_q     <= '0;
            per_act_q <= period_stage;
            run_q     <= 1'b1;
        end else if (run_q && tick) begin
            if (at_period) begin
                if (cont) begin
                    cnt_q     <= '0;
                    per_act_q <= period_stage;
                end else begin
                    run_q <= 1'b0;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pit_regs.sv
module pit_regs
    import pit_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CNT_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_rd,
    input  logic [CW-1:0] count,
    input  logic          running,
    input  logic          hit,
    output ctrl_req_t     req,
    output mode_t         mode,
    output logic [CW-1:0] period_stage,
    output logic [DW-1:0] bus_rdata,
    output logic          match_flag,
    output logic [DW-1:0] shadow_hi
);
    localparam int NW = CW / DW;

    logic          wr_ctrl;
    logic          start_ok;
    logic [DW-1:0] per_q [NW];
    logic [DW-1:0] shadow_q;
    logic          flag_q;

    assign wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
    assign req.srst  = wr_ctrl && bus_wdata[SRST_BIT];
    assign req.start = wr_ctrl && bus_wdata[GO_BIT] && !bus_wdata[SRST_BIT];
    assign start_ok  = req.start && !running;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= '0;
        end else if (bus_wr && (bus_addr == A_MODE)) begin
            mode <= unpack_mode(bus_wdata);
        end
    end

    for (genvar w = 0; w < NW; w++) begin : g_per
        localparam logic [AW-1:0] WADDR = A_PER_LO + AW'(4 * w);
        always_ff @(posedge clk) begin
            if (rst) begin
                per_q[w] <= '0;
            end else if (bus_wr && (bus_addr == WADDR)) begin
                per_q[w] <= bus_wdata;
            end
        end
        assign period_stage[w*DW +: DW] = per_q[w];
    end

    always_ff @(posedge clk) begin
        if (rst || req.srst) begin
            flag_q <= 1'b0;
        end else if (start_ok) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
        end else if (bus_rd && (bus_addr == A_CNT_LO)) begin
            shadow_q <= count[CW-1 -: DW];
        end
    end

    assign match_flag = flag_q;
    assign shadow_hi  = shadow_q;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL)   bus_rdata[GO_BIT] = running;
        if (bus_addr == A_MODE)   bus_rdata = pack_mode(mode);
        if (bus_addr == A_CNT_LO) bus_rdata = count[DW-1:0];
        if (bus_addr == A_CNT_HI) bus_rdata = shadow_q;
        for (int w = 0; w < NW; w++) begin
            if (bus_addr == A_PER_LO + AW'(4 * w)) bus_rdata = per_q[w];
        end
    end
endmodule

// File: rtl/pit_timer64.sv
module pit_timer64
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              match_flag
);
    ctrl_req_t         req;
    mode_t             mode;
    logic [CNT_W-1:0]  period_stage;
    logic [CNT_W-1:0]  count;
    logic [DATA_W-1:0] shadow_hi;
    logic              running;
    logic              hit;
    logic              tick;
    logic              pre_clear;

    assign pre_clear = req.srst || (req.start && !running);

    pit_regs #(.DW(DATA_W), .CW(CNT_W), .AW(ADDR_W)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_wdata    (bus_wdata),
        .bus_rd       (bus_rd),
        .count        (count),
        .running      (running),
        .hit          (hit),
        .req          (req),
        .mode         (mode),
        .period_stage (period_stage),
        .bus_rdata    (bus_rdata),
        .match_flag   (match_flag),
        .shadow_hi    (shadow_hi)
    );

    pit_prescaler #(.PW(PRE_W)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .clear (pre_clear),
        .run   (running),
        .limit (mode.presc),
        .tick  (tick)
    );

    pit_counter #(.CW(CNT_W)) u_cnt (
        .clk          (clk),
        .rst          (rst),
        .srst         (req.srst),
        .start        (req.start),
        .tick         (tick),
        .cont         (mode.cont),
        .period_stage (period_stage),
        .count        (count),
        .running      (running),
        .hit          (hit)
    );
endmodule

// File: rtl/pit_timer64_chk.sv
module pit_timer64_chk
    import pit_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              srst_bit,
    input logic              bus_rd,
    input logic [CNT_W-1:0]  count,
    input logic [DATA_W-1:0] shadow_hi,
    input logic              running,
    input logic              match_flag
);
    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (count != $past(count)) |-> (count == $past(count) + 1'b1 || count == '0));

    // R8
    idle_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (!running && !bus_wr) |=> $stable(count));

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (match_flag && !(bus_wr && bus_addr == A_CTRL)) |=> match_flag);

    // R3
    soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_CTRL && srst_bit) |=> (!running && count == '0 && !match_flag));

    // R10
    shadow_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == A_CNT_LO) |=> (shadow_hi == $past(count[CNT_W-1 -: DATA_W])));
endmodule

bind pit_timer64 pit_timer64_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .srst_bit   (bus_wdata[pit_pkg::SRST_BIT]),
    .bus_rd     (bus_rd),
    .count      (count),
    .shadow_hi  (shadow_hi),
    .running    (running),
    .match_flag (match_flag)
);

// File: tb/sim_pit_timer64.sv
module sim_pit_timer64;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        match_flag;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] rd_val;
    logic        rd_flag;

    always #(CLK_PERIOD/2) clk = ~clk;

    pit_timer64 u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .match_flag(match_flag)
    );

    typedef struct packed {
        logic [3:0]  presc;
        logic [31:0] per;
        logic        cont;
        logic [15:0] wt;
        logic [31:0] cnt;
        logic        mt;
        logic        rn;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{4'd0,  32'd100,  1'b1, 16'd10, 32'd10, 1'b0, 1'b1},
        '{4'd3,  32'd100,  1'b1, 16'd20, 32'd5,  1'b0, 1'b1},
        '{4'd0,  32'd5,    1'b1, 16'd6,  32'd0,  1'b1, 1'b1},
        '{4'd0,  32'd5,    1'b0, 16'd10, 32'd5,  1'b1, 1'b0},
        '{4'd15, 32'd1000, 1'b1, 16'd64, 32'd4,  1'b0, 1'b1},
        '{4'd1,  32'd3,    1'b1, 16'd9,  32'd0,  1'b1, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 rd_val = bus_rdata; rd_flag = match_flag;
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        bus_read(8'h00); chk("R1 ctrl", rd_val, 32'h0);
        chk("R1 flag", {31'b0, rd_flag}, 32'h0);
        bus_read(8'h20); chk("R1 count lo", rd_val, 32'h0);
        bus_read(8'h04); chk("R1 mode", rd_val, 32'h0);
        bus_read(8'h08); chk("R1 period lo", rd_val, 32'h0);

        // Table: R5 R6 R7 R8 R2 R10 R4
        for (int i = 0; i < 6; i++) begin
            bus_write(8'h00, 32'h100);
            bus_write(8'h04, {20'b0, VEC[i].presc, 7'b0, VEC[i].cont});
            bus_write(8'h08, VEC[i].per);
            bus_write(8'h0C, 32'h0);
            bus_write(8'h00, 32'h1);
            repeat (int'(VEC[i].wt)) @(posedge clk);
            bus_read(8'h20);
            chk($sformatf("R5/R7/R8 row%0d count", i), rd_val, VEC[i].cnt);
            chk($sformatf("R6 row%0d flag", i), {31'b0, rd_flag}, {31'b0, VEC[i].mt});
            bus_read(8'h00);
            chk($sformatf("R2/R8 row%0d running", i), rd_val, {31'b0, VEC[i].rn});
            bus_read(8'h24);
            chk($sformatf("R10 row%0d shadow", i), rd_val, 32'h0);
            bus_read(8'h04);
            chk($sformatf("R4 row%0d mode", i), rd_val, {20'b0, VEC[i].presc, 7'b0, VEC[i].cont});
        end

        // R6: start clears the flag after a one-shot stop (row 5 left it set; redo one-shot)
        bus_write(8'h00, 32'h100);
        bus_write(8'h04, 32'h0);
        bus_write(8'h08, 32'd2);
        bus_write(8'h00, 32'h1);
        repeat (5) @(posedge clk);
        bus_read(8'h20); chk("R8 oneshot hold", rd_val, 32'd2);
        chk("R6 flag set", {31'b0, rd_flag}, 32'h1);
        bus_write(8'h00, 32'h1);
        bus_read(8'h00); chk("R6 start clears flag", {31'b0, rd_flag}, 32'h0);
        chk("R2 restart running", rd_val, 32'h1);

        // R2: write of 0 and start while running are ignored
        bus_write(8'h00, 32'h100);
        bus_write(8'h04, 32'h1);
        bus_write(8'h08, 32'd1000);
        bus_write(8'h00, 32'h1);
        bus_write(8'h00, 32'h0);
        bus_read(8'h00); chk("R2 zero write ignored", rd_val, 32'h1);
        bus_write(8'h00, 32'h1);
        bus_read(8'h20); chk("R2 start while running ignored", rd_val, 32'd3);

        // R9: period written while running takes effect at the next wrap
        bus_write(8'h00, 32'h100);
        bus_write(8'h08, 32'd3);
        bus_write(8'h00, 32'h1);
        bus_write(8'h08, 32'd10);
        repeat (7) @(posedge clk);
        bus_read(8'h20); chk("R9 staged period deferred", rd_val, 32'd4);
        bus_read(8'h08); chk("R9 staged readback", rd_val, 32'd10);

        // R3: software reset keeps configuration, clears state; wins over start
        bus_write(8'h00, 32'h101);
        bus_read(8'h00); chk("R3 reset wins", rd_val, 32'h0);
        chk("R3 flag cleared", {31'b0, rd_flag}, 32'h0);
        bus_read(8'h20); chk("R3 count cleared", rd_val, 32'h0);
        bus_read(8'h04); chk("R3 mode kept", rd_val, 32'h1);
        bus_read(8'h08); chk("R3 period kept", rd_val, 32'd10);

        // R11: unmapped address
        bus_write(8'h10, 32'hDEADBEEF);
        bus_read(8'h10); chk("R11 unmapped reads 0", rd_val, 32'h0);
        bus_read(8'h0C); chk("R11 period hi untouched", rd_val, 32'h0);
        bus_read(8'h04); chk("R11 mode untouched", rd_val, 32'h1);

        finish_run();
    end
endmodule